// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns characters written by a processor into an asynchronous serial stream on a single output line. A mode word supplied as a plain input sets how each character is framed: 5 to 8 data bits sent least significant bit first, an optional odd or even parity bit, one, one and a half or two stop bits, and a bit period of 1, 16 or 64 periods of an external transmit clock. The mode word is captured when a character starts, so a new mode applies from the next character on.

A one-character holding register lets the processor write the next character while the current one shifts out, so characters can follow each other with no idle time between them. A character only starts while the clear-to-send input and the transmit-enable input are both high. A break input holds the line low for as long as it is set and abandons any character in flight. When nothing is pending the line rests at mark (high).

All logic runs on the system clock. The transmit clock is synchronised, and each of its falling edges becomes a one-cycle tick; the line changes only on such ticks.

Top module: `async_tx_core`

## Requirements
- R1: A frame starts with one low start bit, followed by the data bits least significant first; mode bits [3:2] give the character length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits), and the frame ends with high stop bits.
- R2: When mode bit 4 is 1, one parity bit follows the last data bit and comes before the stop bits; mode bit 5 = 1 makes the count of ones in data plus parity even, and 0 makes it odd. When mode bit 4 is 0 no parity bit is sent.
- R3: A pending character starts only while both `cts` and `tx_en` are high; while either is low the line stays at mark and the character waits.
- R4: Mode bits [1:0] select the bit period: 00 = 1, 01 = 16, 10 or 11 = 64 ticks, one tick for each falling edge of `txc`. The line changes only on a tick, except when the break input changes.
- R5: Mode bits [7:6] select the stop length: 00 = 1 bit, 01 = 1.5 bits, 10 or 11 = 2 bits. With the 1-tick bit period, 1.5 stop bits are sent as 2 ticks.
- R6: With no character pending, the line is high once the stop bits of the last character are done.
- R7: While `brk` is high, `txd` is low from the next clock on, and any frame in progress is dropped. After `brk` falls, `txd` returns high, and a pending character then starts with a new start bit within a few clocks.
- R8: `tx_rdy` is high when the holding register is empty. A write while `tx_rdy` is low is ignored. The holding register is freed in the clock cycle when its character's start bit begins, so a character written during the current frame follows the stop bits with no idle gap.
- R9: After reset, `txd` is high and `tx_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | 8 | Framing and bit-period selection, captured at each start bit |
| txc | input | 1 | Transmit clock; each falling edge is one tick |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send; unused high bits are ignored |
| cts | input | 1 | Clear to send, active high |
| tx_en | input | 1 | Transmit enable, active high |
| brk | input | 1 | Break command; holds the line low |
| txd | output | 1 | Serial output |
| tx_rdy | output | 1 | Holding register empty |

## Verification
The framing is swept over every character length, every parity setting and every stop length at the 1x and 16x bit periods, and over all parity and stop settings for 8-bit characters at 64x. Each configuration sends two characters back to back with different data, and the bit values are sampled at bit centres. The first stop length is measured exactly, so a wrong divisor, a missing or misplaced parity bit, or a stop length of 1.5 versus 2 bits all give a different sample. Separate patterns hold the character back with `cts` or `tx_en` low while a second write is attempted. A break at idle and a break partway through a character show the forced low level and the abandoned frame, and they also show that a character written during the break starts at once after release.

// File: rtl/atx_pkg.sv
package atx_pkg;

   localparam int CHAR_W = 8;
   localparam int MODE_W = 8;
   localparam int TICK_W = 16;

   // mode word field positions
   localparam int M_DIV_LSB  = 0;
   localparam int M_LEN_LSB  = 2;
   localparam int M_PAR_EN   = 4;
   localparam int M_PAR_EVEN = 5;
   localparam int M_STOP_LSB = 6;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP
   } fsm_t;

   typedef struct packed {
      logic [3:0]        nbits;
      logic              par_en;
      logic              par_even;
      logic [TICK_W-1:0] bit_ticks;
      logic [TICK_W-1:0] stop_ticks;
   } frame_cfg_t;

   // Stop length is kept in half-bit units; an odd product rounds up.
   function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m,
                                              input int div_lo,
                                              input int div_mid,
                                              input int div_hi);
      frame_cfg_t c;
      int div;
      int halves;
      case (m[M_DIV_LSB +: 2])
         2'b00:   div = div_lo;
         2'b01:   div = div_mid;
         default: div = div_hi;
      endcase
      case (m[M_STOP_LSB +: 2])
         2'b00:   halves = 2;
         2'b01:   halves = 3;
         default: halves = 4;
      endcase
      c.nbits      = 4'(5 + int'(m[M_LEN_LSB +: 2]));
      c.par_en     = m[M_PAR_EN];
      c.par_even   = m[M_PAR_EVEN];
      c.bit_ticks  = TICK_W'(div);
      c.stop_ticks = TICK_W'((div * halves + 1) / 2);
      return c;
   endfunction

endpackage

// File: rtl/atx_tick_gen.sv
module atx_tick_gen #(
   parameter int SYNC_STAGES  = 2,
   parameter bit TICK_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txc,
   output logic tick
);

   localparam int CHAIN_W = SYNC_STAGES + 1;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-2:0], txc};
   end

   generate
      if (TICK_ON_FALL) begin : g_fall
         assign tick = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];
      end else begin : g_rise
         assign tick = ~chain[CHAIN_W-1] & chain[CHAIN_W-2];
      end
   endgenerate

endmodule

// File: rtl/atx_hold_buf.sv
module atx_hold_buf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_en && !full) begin
         full <= 1'b1;
         data <= wr_data;
      end
   end

endmodule

// File: rtl/atx_bit_timer.sv
module atx_bit_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expire
);

   logic [CNT_W-1:0] rem;

   assign expire = tick && (rem == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rem <= '0;
      else if (load)                 rem <= len;
      else if (tick && rem != '0)    rem <= rem - CNT_W'(1);
   end

endmodule

// File: rtl/atx_frame_engine.sv
module atx_frame_engine
   import atx_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              expire,
   input  frame_cfg_t        cfg,
   input  logic              hold_full,
   input  logic [CHAR_W-1:0] hold_data,
   input  logic              cts,
   input  logic              tx_en,
   input  logic              brk,
   output logic              take,
   output logic              timer_load,
   output logic [CNT_W-1:0]  timer_len,
   output logic              txd,
   output logic              busy
);

   fsm_t              state;
   logic [CHAR_W-1:0] shreg;
   logic [3:0]        left_q;
   logic              has_par_q;
   logic              par_bit_q;
   logic [CNT_W-1:0]  bit_len_q;
   logic [CNT_W-1:0]  stop_len_q;
   logic              brk_q;

   logic              go;
   logic              last_data;
   logic [CHAR_W-1:0] mask;
   logic              par_new;

   always_comb begin
      for (int i = 0; i < CHAR_W; i++) mask[i] = (i < int'(cfg.nbits));
      par_new = (^(hold_data & mask)) ^ ~cfg.par_even;
   end

   assign go        = hold_full && cts && tx_en && !brk && !brk_q;
   assign take      = go && ((state == S_IDLE && tick) || (state == S_STOP && expire));
   assign last_data = (left_q == 4'd0);
   assign busy      = (state != S_IDLE);

   always_comb begin
      timer_load = 1'b0;
      timer_len  = bit_len_q;
      if (take) begin
         timer_load = 1'b1;
         timer_len  = CNT_W'(cfg.bit_ticks);
      end else if (expire && !brk) begin
         case (state)
            S_START: timer_load = 1'b1;
            S_DATA: begin
               timer_load = 1'b1;
               if (last_data && !has_par_q) timer_len = stop_len_q;
            end
            S_PAR: begin
               timer_load = 1'b1;
               timer_len  = stop_len_q;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         txd        <= 1'b1;
         shreg      <= '0;
         left_q     <= '0;
         has_par_q  <= 1'b0;
         par_bit_q  <= 1'b0;
         bit_len_q  <= '0;
         stop_len_q <= '0;
         brk_q      <= 1'b0;
      end else begin
         brk_q <= brk;
         if (brk) begin
            state <= S_IDLE;
            txd   <= 1'b0;
         end else if (take) begin
            state      <= S_START;
            txd        <= 1'b0;
            shreg      <= hold_data;
            left_q     <= cfg.nbits - 4'd1;
            has_par_q  <= cfg.par_en;
            par_bit_q  <= par_new;
            bit_len_q  <= CNT_W'(cfg.bit_ticks);
            stop_len_q <= CNT_W'(cfg.stop_ticks);
         end else if (expire) begin
            case (state)
               S_START: begin
                  state <= S_DATA;
                  txd   <= shreg[0];
                  shreg <= shreg >> 1;
               end
               S_DATA: begin
                  if (last_data) begin
                     if (has_par_q) begin
                        state <= S_PAR;
                        txd   <= par_bit_q;
                     end else begin
                        state <= S_STOP;
                        txd   <= 1'b1;
                     end
                  end else begin
                     txd    <= shreg[0];
                     shreg  <= shreg >> 1;
                     left_q <= left_q - 4'd1;
                  end
               end
               S_PAR: begin
                  state <= S_STOP;
                  txd   <= 1'b1;
               end
               default: begin
                  state <= S_IDLE;
                  txd   <= 1'b1;
               end
            endcase
         end else if (state == S_IDLE) begin
            txd <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/async_tx_core.sv
module async_tx_core
   import atx_pkg::*;
#(
   parameter int DIV_LO       = 1,
   parameter int DIV_MID      = 16,
   parameter int DIV_HI       = 64,
   parameter int SYNC_STAGES  = 2,
   parameter bit TICK_ON_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              txc,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              cts,
   input  logic              tx_en,
   input  logic              brk,
   output logic              txd,
   output logic              tx_rdy
);

   localparam int MAX_TICKS = (DIV_HI * 4 + 1) / 2;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   generate
      if (DIV_LO < 1 || DIV_MID < DIV_LO || DIV_HI < DIV_MID) begin : g_bad_div
         $error("async_tx_core: divisors must be positive and ascending");
      end
      if (MAX_TICKS >= (1 << TICK_W)) begin : g_bad_range
         $error("async_tx_core: DIV_HI too large for tick fields");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("async_tx_core: at least one synchroniser stage needed");
      end
   endgenerate

   frame_cfg_t        cfg;
   logic              tick;
   logic              take;
   logic              busy;
   logic              hold_full;
   logic [CHAR_W-1:0] hold_data;
   logic              timer_load;
   logic [CNT_W-1:0]  timer_len;
   logic              expire;

   assign cfg    = decode_mode(mode_word, DIV_LO, DIV_MID, DIV_HI);
   assign tx_rdy = ~hold_full;

   atx_tick_gen #(
      .SYNC_STAGES (SYNC_STAGES),
      .TICK_ON_FALL(TICK_ON_FALL)
   ) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .txc  (txc),
      .tick (tick)
   );

   atx_hold_buf #(
      .W(CHAR_W)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .take   (take),
      .full   (hold_full),
      .data   (hold_data)
   );

   atx_bit_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (timer_load),
      .len   (timer_len),
      .expire(expire)
   );

   atx_frame_engine #(
      .CNT_W(CNT_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .expire    (expire),
      .cfg       (cfg),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .cts       (cts),
      .tx_en     (tx_en),
      .brk       (brk),
      .take      (take),
      .timer_load(timer_load),
      .timer_len (timer_len),
      .txd       (txd),
      .busy      (busy)
   );

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic brk,
   input logic cts,
   input logic tx_en,
   input logic txd,
   input logic tx_rdy,
   input logic tick,
   input logic take,
   input logic busy
);

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cts && tx_en && !brk)); // R3

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !txd); // R1

   AST_RDY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> tx_rdy); // R8

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_rdy && !take) |=> !tx_rdy); // R8

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !take && !brk) |=> txd); // R6

   AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !txd); // R7

   AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !brk && !$past(brk)) |=> $stable(txd)); // R4

endmodule

bind async_tx_core async_tx_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .brk   (brk),
   .cts   (cts),
   .tx_en (tx_en),
   .txd   (txd),
   .tx_rdy(tx_rdy),
   .tick  (tick),
   .take  (take),
   .busy  (busy)
);

// File: tb/async_tx_core_tb.sv
module async_tx_core_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mode_word = 8'h0C;
   logic       txc = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       cts = 1'b1;
   logic       tx_en = 1'b1;
   logic       brk = 1'b0;
   logic       txd;
   logic       tx_rdy;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   initial begin
      #1;
      forever #4 txc = ~txc;
   end

   async_tx_core u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_word(mode_word),
      .txc      (txc),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cts      (cts),
      .tx_en    (tx_en),
      .brk      (brk),
      .txd      (txd),
      .tx_rdy   (tx_rdy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int div_of(input int dsel);
      return (dsel == 0) ? 1 : (dsel == 1) ? 16 : 64;
   endfunction

   function automatic int stop_ticks_of(input int div, input int ssel);
      int halves;
      halves = (ssel == 0) ? 2 : (ssel == 1) ? 3 : 4;
      if (div == 1) return (ssel == 0) ? 1 : 2;
      return div * halves / 2;
   endfunction

   task automatic write_char(input logic [7:0] d);
      @(negedge clk);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_start(output int waited);
      waited = 0;
      while (txd !== 1'b0 && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      chk(waited < 5000, "R1", "start bit seen", waited, 0);
   endtask

   // Entered at the first clock sample where the start bit is low.
   task automatic decode(input int div, input int nb, input bit pe, input bit pev,
                         input int sticks, input logic [7:0] d,
                         input bit second, input logic [7:0] d2,
                         input bit follow);
      int p;
      int cnt;
      int cap;
      logic par;
      p = 2 * div;
      chk(tx_rdy === 1'b1, "R8", "holding freed at start bit", int'(tx_rdy), 1);
      if (second) begin
         wr_data = d2;
         wr_en   = 1'b1;
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (p / 2 - 1) @(negedge clk);
      chk(txd === 1'b0, "R1", "start bit low", int'(txd), 0);
      par = 1'b0;
      for (int i = 0; i < nb; i++) begin
         repeat (p) @(negedge clk);
         chk(txd === d[i], "R1", $sformatf("data bit %0d", i), int'(txd), int'(d[i]));
         par = par ^ d[i];
      end
      if (pe) begin
         repeat (p) @(negedge clk);
         if (!pev) par = ~par;
         chk(txd === par, "R2", "parity bit", int'(txd), int'(par));
      end
      repeat (p / 2) @(negedge clk);
      cap = sticks * 2 + 8;
      cnt = 0;
      while (txd === 1'b1 && cnt < cap) begin
         cnt++;
         @(negedge clk);
      end
      if (follow)
         chk(cnt == sticks * 2, "R5", "stop length in clocks", cnt, sticks * 2);
      else
         chk(cnt == cap, "R6", "idle mark after frame", cnt, cap);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL all watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int w;
      int idx;
      bit held;
      logic [7:0] d1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R9", "txd after reset", int'(txd), 1);
      chk(tx_rdy === 1'b1, "R9", "tx_rdy after reset", int'(tx_rdy), 1);

      // framing sweep: divisor x length x parity x stop
      idx = 0;
      for (int ds = 0; ds < 3; ds++)
         for (int ln = 0; ln < 4; ln++)
            for (int pm = 0; pm < 3; pm++)
               for (int ss = 0; ss < 3; ss++) begin
                  if (ds == 2 && ln != 3) continue;
                  @(negedge clk);
                  mode_word = {ss[1:0], (pm == 2), (pm != 0), ln[1:0], ds[1:0]};
                  d1 = 8'((idx * 37 + 8'h5A) & 8'hFF);
                  idx++;
                  write_char(d1);
                  wait_start(w);
                  decode(div_of(ds), ln + 5, pm != 0, pm == 2,
                         stop_ticks_of(div_of(ds), ss), d1, 1'b1, ~d1, 1'b1);
                  decode(div_of(ds), ln + 5, pm != 0, pm == 2,
                         stop_ticks_of(div_of(ds), ss), ~d1, 1'b0, 8'h00, 1'b0);
               end

      // R3: clear-to-send low holds the character, extra write is ignored (R8)
      mode_word = 8'h0C;
      cts = 1'b0;
      write_char(8'hA5);
      held = 1'b1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) held = 1'b0;
      end
      chk(held, "R3", "line at mark while cts low", int'(held), 1);
      chk(tx_rdy === 1'b0, "R8", "tx_rdy low with char pending", int'(tx_rdy), 0);
      write_char(8'h3C);
      cts = 1'b1;
      wait_start(w);
      decode(1, 8, 1'b0, 1'b0, 1, 8'hA5, 1'b0, 8'h00, 1'b0);
      chk(tx_rdy === 1'b1, "R8", "ignored write left register empty", int'(tx_rdy), 1);

      // R3: transmit enable low holds the character
      tx_en = 1'b0;
      write_char(8'h96);
      held = 1'b1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) held = 1'b0;
      end
      chk(held, "R3", "line at mark while tx_en low", int'(held), 1);
      tx_en = 1'b1;
      wait_start(w);
      decode(1, 8, 1'b0, 1'b0, 1, 8'h96, 1'b0, 8'h00, 1'b0);

      // R7: break at idle
      @(negedge clk);
      brk = 1'b1;
      @(negedge clk);
      held = 1'b1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (txd !== 1'b0) held = 1'b0;
      end
      chk(held, "R7", "line low during idle break", int'(held), 1);
      brk = 1'b0;
      @(negedge clk);
      chk(txd === 1'b1, "R7", "mark after break release", int'(txd), 1);

      // R7: break in the middle of a frame, new char written during break
      mode_word = 8'h0D;
      write_char(8'hFF);
      wait_start(w);
      repeat (60) @(negedge clk);
      brk = 1'b1;
      write_char(8'h5A);
      held = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (txd !== 1'b0) held = 1'b0;
      end
      chk(held, "R7", "line low during frame break", int'(held), 1);
      brk = 1'b0;
      @(negedge clk);
      chk(txd === 1'b1, "R7", "mark after mid-frame break", int'(txd), 1);
      wait_start(w);
      chk(w < 8, "R7", "fresh start soon after release", w, 0);
      decode(16, 8, 1'b0, 1'b0, 16, 8'h5A, 1'b0, 8'h00, 1'b0);

      // R4: mode 11 in the divisor field behaves as 64
      mode_word = 8'h0F;
      write_char(8'hC3);
      wait_start(w);
      decode(64, 8, 1'b0, 1'b0, 64, 8'hC3, 1'b0, 8'h00, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule